// File: doc/BRIEF.md
# Programmable Interrupt Line Multiplexer

This block routes a wide vector of interrupt request inputs onto a small set of interrupt lines that go to a processor's interrupt controller. Each output line has its own select register. Software writes into it the number of the input that the line should follow. Input numbering starts at one. A select value of zero, or any value beyond the last input, ties the line to a default level of logic 0. This lets a line be parked without giving up an input position.

The register bus is a single-cycle write port plus a combinational read port. Word address 0 is a control word: writing a 1 in its bit 0 clears every selection at once. Word addresses 1 to N_LINE hold the select registers of lines 0 to N_LINE-1. Each output line is registered, so the line reflects the selection and the inputs present at the previous clock edge. Prioritising, latching and acknowledging interrupts are left to the controller downstream.

Top module: `irq_route_mux`

## Requirements
- R1: After reset every select register reads 0 and every output line is 0.
- R2: Select register of line i sits at word address i+1 and is written when reg_we is high. It stores the low SEL_W bits of reg_wdata (SEL_W = clog2(N_SRC+1), 6 by default) and reads back zero-extended on reg_rdata in the same cycle the address is presented.
- R3: A select value s in 1..N_SRC makes the line follow irq_src[s-1], so value 1 picks the least significant input bit.
- R4: A select value of 0 drives the line to logic 0 whatever the inputs are.
- R5: A select value greater than N_SRC drives the line to logic 0.
- R6: A write to address 0 with bit 0 set clears all select registers and all output lines at that clock edge. A write to address 0 with bit 0 clear changes nothing. Address 0 always reads 0.
- R7: Output lines are registered. An input change or a new selection shows on irq_line one clock edge after it is presented. Until then the line keeps its previous value.
- R8: Several lines may select the same input, and all of them follow it.
- R9: Writes to addresses above N_LINE change no select register, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| irq_src | input | N_SRC | Interrupt request inputs, bit 0 is input number 1 |
| irq_line | output | N_LINE | Routed interrupt lines |

## Verification
Directed patterns come first. A walking input bit under fixed selections tells a correct 1-based mapping apart from an off-by-one. Selects of 0 and of values just past N_SRC, with all inputs high, separate the default level from a stray input. A write that carries high garbage bits shows truncation to the select field. Shared selections, a control-word write with and without bit 0, and unmapped writes show the clear and the ignore behaviour. Observing the outputs on both sides of the edge confirms the one-cycle latency. Random select values (including out-of-range ones) mixed with random input vectors then compare every line against a bench model of the routing rule.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

  typedef enum logic [1:0] {
    RK_CTRL = 2'd0,
    RK_SEL  = 2'd1,
    RK_NONE = 2'd2
  } reg_kind_e;

  // Classify a word address: 0 is the control word, 1..n_line the selects.
  function automatic reg_kind_e classify(input int unsigned addr, input int unsigned n_line);
    if (addr == 0)           return RK_CTRL;
    else if (addr <= n_line) return RK_SEL;
    else                     return RK_NONE;
  endfunction

endpackage

// File: rtl/irqmux_rst_sync.sv
module irqmux_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irqmux_regs.sv
module irqmux_regs
  import irqmux_pkg::*;
#(
  parameter int N_LINE = 4,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    soft_clr,
  output logic [N_LINE*SEL_W-1:0] sel_flat
);
  reg_kind_e kind;

  always_comb begin
    kind     = classify(int'(reg_addr), N_LINE);
    soft_clr = reg_we && (kind == RK_CTRL) && reg_wdata[0];
  end

  for (genvar i = 0; i < N_LINE; i++) begin : g_sel
    logic             hit;
    logic             sel_en;
    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
      hit    = reg_we && (reg_addr == ADDR_W'(i + 1));
      sel_en = soft_clr || hit;
      sel_d  = soft_clr ? '0 : reg_wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_en) sel_q <= sel_d;
    end

    assign sel_flat[i*SEL_W +: SEL_W] = sel_q;

    // R2: a write to this line's address lands in its select field
    a_r2_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(i + 1)) |=> (sel_q == $past(reg_wdata[SEL_W-1:0])));
  end

  always_comb begin
    reg_rdata = '0;
    if (kind == RK_SEL) begin
      for (int i = 0; i < N_LINE; i++) begin
        if (reg_addr == ADDR_W'(i + 1)) reg_rdata = DATA_W'(sel_flat[i*SEL_W +: SEL_W]);
      end
    end
  end

  // R6: a clear pulse empties every select register
  a_r6_clear_all : assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && reg_wdata[0]) |=> (sel_flat == '0));

  // R9: without a write strobe the selections hold
  a_r9_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(sel_flat));
endmodule

// File: rtl/irqmux_lane.sv
module irqmux_lane #(
  parameter int N_SRC = 32,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] src,
  output logic             line
);
  logic pick;
  logic line_d;
  logic line_q;

  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel == SEL_W'(k + 1)) pick = src[k];
    end
    line_d = clr ? 1'b0 : pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign line = line_q;

  // R3: an in-range select follows its input one edge later
  a_r3_follow_src : assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel != '0 && sel <= SEL_W'(N_SRC))
      |=> (line == $past(|(src & (N_SRC'(1) << (sel - SEL_W'(1)))))));

  // R4: select zero parks the line low
  a_r4_zero_default : assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> !line);

  // R5: out-of-range select parks the line low
  a_r5_range_default : assert property (@(posedge clk) disable iff (!rst_n)
    (sel > SEL_W'(N_SRC)) |=> !line);
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux #(
  parameter int N_SRC  = 32,
  parameter int N_LINE = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  irq_src,
  output logic [N_LINE-1:0] irq_line
);
  localparam int SEL_W = $clog2(N_SRC + 1);

  logic                    rst_sync_n;
  logic                    soft_clr;
  logic [N_LINE*SEL_W-1:0] sel_flat;

  irqmux_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqmux_regs #(
    .N_LINE (N_LINE),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .soft_clr  (soft_clr),
    .sel_flat  (sel_flat)
  );

  for (genvar i = 0; i < N_LINE; i++) begin : g_lane
    irqmux_lane #(
      .N_SRC (N_SRC),
      .SEL_W (SEL_W)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (soft_clr),
      .sel   (sel_flat[i*SEL_W +: SEL_W]),
      .src   (irq_src),
      .line  (irq_line[i])
    );
  end

  // R6: a clear pulse drops every line at the same edge
  a_r6_lines_drop : assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_clr |=> (irq_line == '0));
endmodule

// File: tb/irq_route_mux_tb.sv
module irq_route_mux_tb;
  localparam int N_SRC  = 32;
  localparam int N_LINE = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [N_SRC-1:0]  irq_src = '0;
  logic [N_LINE-1:0] irq_line;

  int checks = 0;
  int errors = 0;
  int model_sel [N_LINE];
  logic [N_SRC-1:0] model_src = '0;

  always #5 clk = ~clk;

  irq_route_mux #(.N_SRC(N_SRC), .N_LINE(N_LINE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src), .irq_line(irq_line)
  );

  function automatic logic route(int s, logic [N_SRC-1:0] v);
    if (s >= 1 && s <= N_SRC) return v[s-1];
    return 1'b0;
  endfunction

  function automatic logic [N_LINE-1:0] expect_lines(logic [N_SRC-1:0] v);
    logic [N_LINE-1:0] r;
    for (int i = 0; i < N_LINE; i++) r[i] = route(model_sel[i], v);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a write at the falling edge, let one rising edge take it.
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    if (a >= 1 && a <= N_LINE) model_sel[a-1] = int'(d[5:0]);
    if (a == 0 && d[0]) for (int i = 0; i < N_LINE; i++) model_sel[i] = 0;
  endtask

  task automatic rd_check(string req, int a, logic [31:0] exp);
    reg_addr = ADDR_W'(a);
    #1;
    check(req, reg_rdata, exp);
  endtask

  // Present a new input vector, cross one edge, compare every line.
  task automatic step(string req, logic [N_SRC-1:0] v);
    @(negedge clk);
    irq_src = v; model_src = v;
    @(posedge clk);
    @(negedge clk);
    check(req, 32'(irq_line), 32'(expect_lines(v)));
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N_LINE; i++) model_sel[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < N_LINE; i++) rd_check("R1 select after reset", i + 1, 0);
    check("R1 lines after reset", 32'(irq_line), 0);

    // R2: write/readback and truncation to the select field
    wr(1, 32'd3); wr(2, 32'd32); wr(3, 32'hFFFF_FFC5); wr(4, 32'd1);
    rd_check("R2 readback line0", 1, 3);
    rd_check("R2 readback line1", 2, 32);
    rd_check("R2 truncated line2", 3, 5);
    rd_check("R2 readback line3", 4, 1);

    // R3: walking single input bit
    for (int b = 0; b < N_SRC; b++) step("R3 walking bit", N_SRC'(1) << b);
    step("R3 all ones", '1);

    // R4/R5: parked lines under all-ones inputs
    wr(1, 32'd0); wr(2, 32'd33); wr(3, 32'd63); wr(4, 32'd32);
    step("R4 R5 default level", '1);
    check("R4 select zero low", 32'(irq_line[0]), 0);
    check("R5 select 33 low", 32'(irq_line[1]), 0);
    check("R5 select 63 low", 32'(irq_line[2]), 0);
    check("R3 select 32 top bit", 32'(irq_line[3]), 1);

    // R8: shared selection
    for (int i = 1; i <= N_LINE; i++) wr(i, 32'd7);
    step("R8 shared input high", N_SRC'(1) << 6);
    check("R8 all lines high", 32'(irq_line), 32'hF);
    step("R8 shared input low", ~(N_SRC'(1) << 6));
    check("R8 all lines low", 32'(irq_line), 0);

    // R7: latency of an input change
    wr(1, 32'd3);
    step("R7 setup", '0);
    @(negedge clk);
    irq_src = N_SRC'(1) << 2;
    #1;
    check("R7 line holds before edge", 32'(irq_line[0]), 0);
    @(posedge clk); @(negedge clk);
    check("R7 line after edge", 32'(irq_line[0]), 1);
    // R7: latency of a selection change (input 4 high, input 3 low)
    step("R7 setup2", N_SRC'(1) << 3);
    check("R7 old select low", 32'(irq_line[0]), 0);
    wr(1, 32'd4);
    check("R7 old select still applies", 32'(irq_line[0]), 0);
    step("R7 new select applies", N_SRC'(1) << 3);

    // R9: unmapped address
    wr(1, 32'd1); wr(2, 32'd2); wr(3, 32'd3); wr(4, 32'd4);
    wr(9, 32'd7); wr(15, 32'hFFFF_FFFF);
    rd_check("R9 unmapped reads 0", 9, 0);
    for (int i = 0; i < N_LINE; i++) rd_check("R9 select unchanged", i + 1, i + 1);
    step("R9 routing unchanged", 32'h0000_000F);
    check("R9 lines", 32'(irq_line), 32'hF);

    // R6: control word without bit 0, then with bit 0
    wr(0, 32'hFFFF_FFFE);
    rd_check("R6 ctrl reads 0", 0, 0);
    for (int i = 0; i < N_LINE; i++) rd_check("R6 no clear without bit0", i + 1, i + 1);
    check("R6 lines kept", 32'(irq_line), 32'hF);
    wr(0, 32'd1);
    check("R6 lines cleared at edge", 32'(irq_line), 0);
    for (int i = 0; i < N_LINE; i++) rd_check("R6 select cleared", i + 1, 0);
    step("R6 lines stay low", '1);

    // Random mix: R3 R4 R5 R8 against the model
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 1) == 1)
        wr($urandom_range(1, N_LINE), 32'($urandom_range(0, N_SRC + 3)));
      step("R3 R4 R5 random", N_SRC'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule